// File: doc/BRIEF.md
# Pilot Code-Phase Searcher with Two-Stage Dwell

This block decides whether the local pseudo-noise (PN) code phase lines up with the pilot in a received spread-spectrum signal. Each accepted chip sample is despread against the local in-phase and quadrature PN chips. The two despread values are summed coherently over a programmable number of chips. From the two coherent sums the block forms a cheap energy metric: the larger of their magnitudes. No squaring is done.

A first dwell screens the phase against one threshold. If the phase survives, a second stage adds the metrics of several further dwells and tests the total against a second threshold. If the phase fails either test, the block emits a one-cycle slew request so that the external PN generator advances by one chip, and the search starts over. When the second test passes, the block raises a sticky done flag and presents the final summed metric. The PN generator is outside the block. Software restarts a search by dropping and raising the enable.

Top module: `pilot_searcher`

## Requirements
- R1: The despread values are computed as `din_i = rx_i*ci + rx_q*cq` and `dquad = rx_i*cq - rx_q*ci`. Each chip value comes from its chip bit: bit 0 stands for +1 and bit 1 stands for -1, so multiplying by a chip is a conditional negation.
- R2: A dwell lasts `nc_m1+1` accepted samples. A sample is accepted only when `smp_vld` is high, a dwell stage is active and no slew pulse is in progress. The coherent sums collect the despread values of the accepted samples only.
- R3: The dwell metric equals max(|YI|, |YQ|) exactly. The two magnitude bits just below the sign bit are compared first, and the full-width comparison decides only when those two bits are equal.
- R4: At the end of a first-stage dwell, a metric strictly greater than `thr1` moves the block to the second stage. A metric equal to or below `thr1` causes a slew.
- R5: The second stage adds the metrics of `nn_m1+1` consecutive dwells. If the total is strictly greater than `thr2`, `done_o` rises and `metric_o` shows the total in the cycle after the last sample. Otherwise the block slews and returns to the first stage.
- R6: `slew_o` is a single-cycle pulse in the cycle after the deciding sample. The coherent sums, the chip counter, the dwell counter and the second-stage total are all zero during that pulse. A sample presented during the pulse is dropped.
- R7: While `srch_en` stays high after a detection, `done_o` stays high, `metric_o` holds its value, further samples have no effect and no slew is issued.
- R8: When `srch_en` is low, the block idles, and `done_o` is low one cycle later. The first sample is accepted one cycle after `srch_en` rises.
- R9: The coherent sums do not overflow for full-scale samples over 256 chips. With amplitude 127, an aligned dwell metric is 65024.
- R10: After reset, `slew_o` and `done_o` are low and `metric_o` is zero.
- R11: For a clean pilot whose code lies D chips ahead of the local phase, `done_o` rises after exactly D slew pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_en | input | 1 | Search enable; low returns the block to idle |
| smp_vld | input | 1 | A chip sample is present this cycle |
| rx_i | input | SMP_W | Received in-phase sample, signed |
| rx_q | input | SMP_W | Received quadrature sample, signed |
| pn_i | input | 1 | Local in-phase chip bit (0 means +1, 1 means -1) |
| pn_q | input | 1 | Local quadrature chip bit (0 means +1, 1 means -1) |
| nc_m1 | input | NC_W | Chips per dwell minus one |
| nn_m1 | input | NN_W | Second-stage dwells minus one |
| thr1 | input | SMP_W+NC_W+2 | First-stage threshold |
| thr2 | input | SMP_W+NC_W+NN_W+2 | Second-stage threshold |
| slew_o | output | 1 | One-cycle request to advance the PN phase by one chip |
| done_o | output | 1 | Pilot phase found; sticky while enabled |
| metric_o | output | SMP_W+NC_W+NN_W+2 | Second-stage total at detection |

## Verification
Every decision is made on the clock edge that takes the last chip of a dwell. Both `slew_o` and a rising `done_o`, together with `metric_o`, are therefore due exactly one cycle after that sample is presented. The bench drives each sample on a falling edge and compares the outputs on the next falling edge against a reference model that is stepped with the same sample. A slew or detection that arrives one cycle early or late is therefore reported in the cycle where the two disagree. The effect of `srch_en` going low is checked one cycle later.

// File: rtl/srch_pkg.sv
package srch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DWELL1 = 2'd1,
    ST_DWELL2 = 2'd2,
    ST_FOUND  = 2'd3
  } srch_st_e;
endpackage

// File: rtl/srch_despread.sv
module srch_despread #(
  parameter int SMP_W = 8
) (
  input  logic signed [SMP_W-1:0] rx_i,
  input  logic signed [SMP_W-1:0] rx_q,
  input  logic                    pn_i,
  input  logic                    pn_q,
  output logic signed [SMP_W+1:0] d_inph,
  output logic signed [SMP_W+1:0] d_quad
);
  localparam int DSP_W = SMP_W + 2;

  logic signed [DSP_W-1:0] xi, xq;
  logic signed [DSP_W-1:0] xi_ci, xq_cq, xi_cq, xq_ci;

  // chip bit 1 means -1: multiply becomes conditional negation (R1)
  always_comb begin
    xi    = DSP_W'(rx_i);
    xq    = DSP_W'(rx_q);
    xi_ci = pn_i ? -xi : xi;
    xq_cq = pn_q ? -xq : xq;
    xi_cq = pn_q ? -xi : xi;
    xq_ci = pn_i ? -xq : xq;
    d_inph = xi_ci + xq_cq;
    d_quad = xi_cq - xq_ci;
  end
endmodule

// File: rtl/srch_coh_acc.sv
module srch_coh_acc #(
  parameter int DSP_W = 10,
  parameter int ACC_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [DSP_W-1:0] d,
  output logic signed [ACC_W-1:0] sum_o,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    sum_o = acc_q + ACC_W'(d);
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum_o;
    else         acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/srch_mag_max.sv
module srch_mag_max #(
  parameter int ACC_W   = 18,
  parameter bit PRECOMP = 1'b1
) (
  input  logic signed [ACC_W-1:0] y_a,
  input  logic signed [ACC_W-1:0] y_b,
  output logic        [ACC_W-1:0] max_o
);
  localparam int PRE_W = 2;
  localparam int PRE_HI = ACC_W - 2;

  logic [ACC_W-1:0] mag_a, mag_b;

  always_comb begin
    mag_a = y_a[ACC_W-1] ? ACC_W'(-y_a) : ACC_W'(y_a);
    mag_b = y_b[ACC_W-1] ? ACC_W'(-y_b) : ACC_W'(y_b);
  end

  generate
    if (PRECOMP) begin : g_pre
      logic [PRE_W-1:0] hi_a, hi_b;
      always_comb begin
        hi_a = mag_a[PRE_HI -: PRE_W];
        hi_b = mag_b[PRE_HI -: PRE_W];
        if (hi_a > hi_b)      max_o = mag_a;
        else if (hi_b > hi_a) max_o = mag_b;
        else                  max_o = (mag_a >= mag_b) ? mag_a : mag_b;
      end
    end else begin : g_full
      always_comb max_o = (mag_a >= mag_b) ? mag_a : mag_b;
    end
  endgenerate

  always_comb begin
    if (!$isunknown({y_a, y_b})) begin
      AST_MAX_EXACT: assert ((max_o >= mag_a) && (max_o >= mag_b) && ((max_o == mag_a) || (max_o == mag_b))); // R3
    end
  end
endmodule

// File: rtl/pilot_searcher.sv
module pilot_searcher
  import srch_pkg::*;
#(
  parameter int SMP_W   = 8,
  parameter int NC_W    = 8,
  parameter int NN_W    = 4,
  parameter bit PRECOMP = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            srch_en,
  input  logic                            smp_vld,
  input  logic signed [SMP_W-1:0]         rx_i,
  input  logic signed [SMP_W-1:0]         rx_q,
  input  logic                            pn_i,
  input  logic                            pn_q,
  input  logic [NC_W-1:0]                 nc_m1,
  input  logic [NN_W-1:0]                 nn_m1,
  input  logic [SMP_W+NC_W+1:0]           thr1,
  input  logic [SMP_W+NC_W+NN_W+1:0]      thr2,
  output logic                            slew_o,
  output logic                            done_o,
  output logic [SMP_W+NC_W+NN_W+1:0]      metric_o
);
  localparam int DSP_W  = SMP_W + 2;
  localparam int ACC_W  = DSP_W + NC_W;
  localparam int NSUM_W = ACC_W + NN_W;
  localparam int LANES  = 2;

  srch_st_e              st_q, st_d;
  logic [NC_W-1:0]       chip_q, chip_d;
  logic [NN_W-1:0]       dwell_q, dwell_d;
  logic [NSUM_W-1:0]     nsum_q, nsum_d;
  logic [NSUM_W-1:0]     metric_q, metric_d;
  logic                  slew_q, slew_d;
  logic                  done_q, done_d;

  logic                  in_dwell, take, last_chip, dwell_end, last_dwell;
  logic                  acc_clr, acc_en, pass1, pass2;
  logic [ACC_W-1:0]      dwell_met;
  logic [NSUM_W-1:0]     nsum_nxt;

  logic signed [DSP_W-1:0] lane_d   [LANES];
  logic signed [ACC_W-1:0] lane_sum [LANES];
  logic signed [ACC_W-1:0] lane_acc [LANES];

  // despread of the current chip (R1)
  srch_despread #(.SMP_W(SMP_W)) u_dsp (
    .rx_i   (rx_i),
    .rx_q   (rx_q),
    .pn_i   (pn_i),
    .pn_q   (pn_q),
    .d_inph (lane_d[0]),
    .d_quad (lane_d[1])
  );

  always_comb begin
    in_dwell   = (st_q == ST_DWELL1) || (st_q == ST_DWELL2);
    take       = smp_vld && in_dwell && !slew_q && srch_en;
    last_chip  = (chip_q == nc_m1);
    dwell_end  = take && last_chip;
    last_dwell = (dwell_q == nn_m1);
    acc_clr    = dwell_end || !in_dwell || !srch_en;
    acc_en     = take && !last_chip;
  end

  // coherent accumulation lanes (R2, R9)
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      srch_coh_acc #(.DSP_W(DSP_W), .ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .d     (lane_d[g]),
        .sum_o (lane_sum[g]),
        .acc_o (lane_acc[g])
      );
    end
  endgenerate

  // energy metric without squaring (R3)
  srch_mag_max #(.ACC_W(ACC_W), .PRECOMP(PRECOMP)) u_mag (
    .y_a   (lane_sum[0]),
    .y_b   (lane_sum[1]),
    .max_o (dwell_met)
  );

  always_comb begin
    nsum_nxt = nsum_q + {{NN_W{1'b0}}, dwell_met};
    pass1    = dwell_met > thr1;
    pass2    = nsum_nxt > thr2;
  end

  // next-state and output logic
  always_comb begin
    st_d     = st_q;
    chip_d   = chip_q;
    dwell_d  = dwell_q;
    nsum_d   = nsum_q;
    metric_d = metric_q;
    slew_d   = 1'b0;
    done_d   = done_q;

    if (!srch_en) begin
      st_d    = ST_IDLE;
      chip_d  = '0;
      dwell_d = '0;
      nsum_d  = '0;
      done_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d    = ST_DWELL1;
          chip_d  = '0;
          dwell_d = '0;
          nsum_d  = '0;
        end
        ST_DWELL1: begin
          if (take) begin
            if (last_chip) begin
              chip_d = '0;
              if (pass1) begin
                st_d    = ST_DWELL2;
                dwell_d = '0;
                nsum_d  = '0;
              end else begin
                slew_d = 1'b1;
              end
            end else begin
              chip_d = chip_q + 1'b1;
            end
          end
        end
        ST_DWELL2: begin
          if (take) begin
            if (last_chip) begin
              chip_d = '0;
              if (last_dwell) begin
                dwell_d = '0;
                nsum_d  = '0;
                if (pass2) begin
                  st_d     = ST_FOUND;
                  done_d   = 1'b1;
                  metric_d = nsum_nxt;
                end else begin
                  st_d   = ST_DWELL1;
                  slew_d = 1'b1;
                end
              end else begin
                nsum_d  = nsum_nxt;
                dwell_d = dwell_q + 1'b1;
              end
            end else begin
              chip_d = chip_q + 1'b1;
            end
          end
        end
        default: begin
          st_d = ST_FOUND;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      chip_q   <= '0;
      dwell_q  <= '0;
      nsum_q   <= '0;
      metric_q <= '0;
      slew_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      chip_q   <= chip_d;
      dwell_q  <= dwell_d;
      nsum_q   <= nsum_d;
      metric_q <= metric_d;
      slew_q   <= slew_d;
      done_q   <= done_d;
    end
  end

  assign slew_o   = slew_q;
  assign done_o   = done_q;
  assign metric_o = metric_q;

  AST_SLEW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slew_q |=> !slew_q); // R6
  AST_SLEW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    slew_q |-> (lane_acc[0] == '0 && lane_acc[1] == '0 && chip_q == '0 &&
                dwell_q == '0 && nsum_q == '0 && st_q == ST_DWELL1)); // R6
  AST_DONE_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (metric_q > thr2)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && srch_en) |=> (done_q && $stable(metric_q))); // R7
  AST_NO_SLEW_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !slew_q); // R7
  AST_IDLE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !done_q); // R8
endmodule

// File: tb/pilot_searcher_tb_top.sv
`timescale 1ns/1ps
module pilot_searcher_tb_top;
  localparam int SMP_W = 8;
  localparam int NC_W  = 8;
  localparam int NN_W  = 4;
  localparam int SEQ_L = 31;

  logic clk = 1'b0;
  logic rst_n;
  logic srch_en, smp_vld, pn_i, pn_q, slew_o, done_o;
  logic signed [SMP_W-1:0] rx_i, rx_q;
  logic [NC_W-1:0] nc_m1;
  logic [NN_W-1:0] nn_m1;
  logic [SMP_W+NC_W+1:0] thr1;
  logic [SMP_W+NC_W+NN_W+1:0] thr2, metric_o;

  always #2.5 clk = ~clk;

  pilot_searcher #(.SMP_W(SMP_W), .NC_W(NC_W), .NN_W(NN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .smp_vld(smp_vld),
    .rx_i(rx_i), .rx_q(rx_q), .pn_i(pn_i), .pn_q(pn_q),
    .nc_m1(nc_m1), .nn_m1(nn_m1), .thr1(thr1), .thr2(thr2),
    .slew_o(slew_o), .done_o(done_o), .metric_o(metric_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  bit seq_i [SEQ_L];
  bit seq_q [SEQ_L];

  // reference model state
  int m_stage, m_chip, m_yi, m_yq, m_dw, m_ns, m_out;
  int cur_ncm1, cur_nnm1, cur_t1, cur_t2;
  bit exp_slew, exp_done;

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cval(bit b);
    return b ? -1 : 1;
  endfunction

  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int clamp(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  // R1..R5 model: one accepted sample
  task automatic m_step(int rxi, int rxq, bit ci, bit cq);
    int oi, oq, met, ns;
    oi = rxi * cval(ci) + rxq * cval(cq);
    oq = rxi * cval(cq) - rxq * cval(ci);
    m_yi += oi;
    m_yq += oq;
    exp_slew = 0;
    exp_done = 0;
    if (m_chip == cur_ncm1) begin
      met = (absi(m_yi) > absi(m_yq)) ? absi(m_yi) : absi(m_yq);
      m_chip = 0; m_yi = 0; m_yq = 0;
      if (m_stage == 1) begin
        if (met > cur_t1) begin m_stage = 2; m_dw = 0; m_ns = 0; end
        else exp_slew = 1;
      end else begin
        ns = m_ns + met;
        if (m_dw == cur_nnm1) begin
          m_dw = 0; m_ns = 0;
          if (ns > cur_t2) begin exp_done = 1; m_out = ns; end
          else begin exp_slew = 1; m_stage = 1; end
        end else begin
          m_ns = ns; m_dw++;
        end
      end
    end else begin
      m_chip++;
    end
  endtask

  task automatic run_case(string tag, int d, int ncm1, int nnm1, int amp, int noise,
                          int t1, int t2, bit rot, bit junk, int cap,
                          int want_slews, bit want_done, int want_metric);
    int t, p, slews, rxi, rxq, tx, lc, si, sq, hold_met;
    @(negedge clk);
    srch_en = 0; smp_vld = 0;
    nc_m1 = NC_W'(ncm1); nn_m1 = NN_W'(nnm1);
    thr1 = ($bits(thr1))'(t1); thr2 = ($bits(thr2))'(t2);
    cur_ncm1 = ncm1; cur_nnm1 = nnm1; cur_t1 = t1; cur_t2 = t2;
    @(negedge clk);
    chk({"R8 ", tag}, "done while disabled", done_o, 0);
    srch_en = 1;
    m_stage = 1; m_chip = 0; m_yi = 0; m_yq = 0; m_dw = 0; m_ns = 0; m_out = 0;
    exp_slew = 0; exp_done = 0; t = 0; p = 0; slews = 0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      chk({"R6 ", tag}, "slew", slew_o, exp_slew);
      chk({"R5 ", tag}, "done", done_o, exp_done);
      if (exp_done) break;
      if (exp_slew) begin
        slews++; p++; exp_slew = 0;
        smp_vld = junk;  // R6: dropped while the slew pulse is high
        rx_i = SMP_W'($urandom_range(0, 255));
        rx_q = SMP_W'($urandom_range(0, 255));
        pn_i = 1'($urandom_range(0, 1)); pn_q = 1'($urandom_range(0, 1));
        if (slews >= cap) break;
        continue;
      end
      tx = (t + d) % SEQ_L;
      lc = (t + p) % SEQ_L;
      si = cval(seq_i[tx]); sq = cval(seq_q[tx]);
      if (rot) begin
        rxi = clamp(-amp * sq + $urandom_range(0, 2 * noise) - noise);
        rxq = clamp(amp * si + $urandom_range(0, 2 * noise) - noise);
      end else begin
        rxi = clamp(amp * si + $urandom_range(0, 2 * noise) - noise);
        rxq = clamp(amp * sq + $urandom_range(0, 2 * noise) - noise);
      end
      smp_vld = 1; rx_i = SMP_W'(rxi); rx_q = SMP_W'(rxq);
      pn_i = seq_i[lc]; pn_q = seq_q[lc];
      m_step(rxi, rxq, seq_i[lc], seq_q[lc]);
      t++;
    end
    smp_vld = 0;
    if (want_slews >= 0) chk({"R11 ", tag}, "slew count", slews, want_slews);
    if (want_done) begin
      chk({"R5 ", tag}, "metric vs model", metric_o, m_out);
      if (want_metric >= 0) chk({"R9 ", tag}, "metric", metric_o, want_metric);
      hold_met = int'(metric_o);
      // R7: samples after detection change nothing
      for (int k = 0; k < 4; k++) begin
        smp_vld = 1;
        rx_i = SMP_W'($urandom_range(0, 255)); rx_q = SMP_W'($urandom_range(0, 255));
        pn_i = 1'($urandom_range(0, 1)); pn_q = 1'($urandom_range(0, 1));
        @(negedge clk);
        chk({"R7 ", tag}, "slew after done", slew_o, 0);
      end
      smp_vld = 0;
      chk({"R7 ", tag}, "done held", done_o, 1);
      chk({"R7 ", tag}, "metric held", metric_o, hold_met);
    end
    srch_en = 0;
    @(negedge clk);
    chk({"R8 ", tag}, "done after disable", done_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] lf;
    void'($urandom(32'd4242));
    lf = 5'b00001;
    for (int k = 0; k < SEQ_L; k++) begin
      seq_i[k] = lf[4];
      lf = {lf[3:0], lf[4] ^ lf[2]};
    end
    for (int k = 0; k < SEQ_L; k++) seq_q[k] = seq_i[(k + 11) % SEQ_L];

    rst_n = 0; srch_en = 0; smp_vld = 0; rx_i = '0; rx_q = '0; pn_i = 0; pn_q = 0;
    nc_m1 = '0; nn_m1 = '0; thr1 = '0; thr2 = '0;
    repeat (3) @(negedge clk);
    chk("R10", "slew at reset", slew_o, 0);
    chk("R10", "done at reset", done_o, 0);
    chk("R10", "metric at reset", metric_o, 0);
    rst_n = 1;

    // R11 / R1 / R2: clean pilot three chips ahead
    run_case("offset3", 3, 15, 1, 20, 0, 320, 1279, 0, 0, 40, 3, 1, 1280);
    // R4: metric equal to thr1 must slew
    run_case("thr1_equal", 0, 3, 0, 10, 0, 80, 79, 0, 0, 1, 1, 0, -1);
    // R5: total equal to thr2 must slew
    run_case("thr2_equal", 0, 3, 0, 10, 0, 79, 80, 0, 0, 1, 1, 0, -1);
    // R5: total one above thr2 detects without slewing
    run_case("thr2_above", 0, 3, 0, 10, 0, 79, 79, 0, 0, 5, 0, 1, 80);
    // R6: junk samples during the slew pulse are dropped
    run_case("slew_junk", 2, 7, 2, 15, 0, 120, 719, 0, 1, 40, 2, 1, 720);
    // R3: pilot on the quadrature branch with negative sum
    run_case("quad_branch", 1, 15, 0, 20, 0, 320, 600, 1, 0, 40, 1, 1, 640);
    // R9 / R3: full scale over 256 chips, exercises the high-bit precompare
    run_case("full_scale", 1, 255, 0, 127, 0, 30000, 60000, 0, 0, 40, 1, 1, 65024);
    // R2 / R4 / R5: noisy random cases against the model
    for (int r = 0; r < 6; r++) begin
      int d, ncm1, nnm1, t1, t2;
      bit rot;
      d = $urandom_range(0, 8);
      ncm1 = $urandom_range(15, 40);
      nnm1 = $urandom_range(0, 3);
      rot = 1'($urandom_range(0, 1));
      t1 = 24 * (ncm1 + 1);
      t2 = ((nnm1 + 1) * 48 * (ncm1 + 1) * 3) / 4;
      run_case("random", d, ncm1, nnm1, 24, 6, t1, t2, rot, 1'($urandom_range(0, 1)),
               60, -1, 1, -1);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule